// File: doc/BRIEF.md
# Loop Buffer Instruction Store

This block sits between an instruction fetch stage and instruction memory. Each instruction that it fetches from memory is kept, together with its address, in a small window. The window holds the most recent fetches in address order and is described by a base address and an entry count. When the fetch stage signals a taken branch, the block compares the target against the window. If the target is inside the window, the instruction comes from the window and memory is not accessed. Fetches that follow in sequence keep reading from the window until the address moves past its last entry. From that point the block fetches from memory again and adds each new instruction to the end of the window.

A loop whose body fits in the window is read from memory on its first pass only. Every later pass starts with a taken branch back to the top of the loop, and that branch hits. The memory is assumed to return data exactly one cycle after a request. The fetch response also arrives one cycle after its request, whether the instruction comes from the window or from memory.

Top module: `loop_buffer`

## Requirements
- R1: After reset no response is valid, no memory request is made and the window is empty, so the first branch target misses.
- R2: Every fetch request gets `f_valid` on the next cycle and never otherwise. `f_instr` then carries the instruction stored at the requested address, including an instruction whose memory data arrives in the same cycle as the branch that hits it.
- R3: A fetch that is not served from the window asserts `m_req` in the same cycle, with `m_addr` equal to `f_addr`. `f_hit` is low in the response.
- R4: A taken branch whose target minus the base is below the count is served from the window. `m_req` stays low and `f_hit` is high in the response.
- R5: A taken branch that misses empties the window and starts it again at the target, with a count of one. This includes a target exactly one past the last entry.
- R6: After a hit, sequential fetches inside the window come from the window. The first one past the end goes to memory and is appended to the window.
- R7: A sequential fetch with no hit in progress goes to memory, even when its address lies inside the window.
- R8: When the window is full, an append drops the oldest entry and advances the base by one. A branch to a dropped address then misses.
- R9: For a loop shorter than the window depth, no memory reads occur after the first pass.
- R10: A memory fetch whose address does not follow the last entry starts the window again at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_req | input | 1 | Fetch request |
| f_branch | input | 1 | This request is the target of a taken branch |
| f_addr | input | AW | Fetch address, in instruction units |
| f_valid | output | 1 | Response valid, one cycle after the request |
| f_instr | output | DW | Fetched instruction |
| f_hit | output | 1 | Response was served from the window |
| m_req | output | 1 | Memory read request |
| m_addr | output | AW | Memory read address |
| m_rdata | input | DW | Memory read data, one cycle after `m_req` |

## Verification
On every cycle the assertions check that a response follows each request one cycle later. They also check that the count never goes beyond the depth, that a branch with no memory request produces a hit, that a branch miss sets the window to the target with a count of one, and that an append to a full window slides the base by one. The bench's scenarios are needed for the rest. Those cover the exact instruction returned, including data forwarded from a memory read into a hit in the next cycle; the absence of memory reads across repeated loop passes; the eviction of an old target; and the difference between a sequential fetch and a branch to the same in-window address.

// File: rtl/loop_buffer.sv
module loop_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_req,
  input  logic          f_branch,
  input  logic [AW-1:0] f_addr,
  output logic          f_valid,
  output logic [DW-1:0] f_instr,
  output logic          f_hit,
  output logic          m_req,
  output logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = IW + 1;

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] base;
  logic [CW-1:0] count;
  logic [IW-1:0] head, wr_slot;
  logic          active, wr_pend, rsp_hit;
  logic [DW-1:0] rd_q;

  function automatic logic [IW-1:0] slot_of(input logic [IW-1:0] h, input logic [CW-1:0] k);
    logic [CW:0] s;
    s = {2'b00, h} + {1'b0, k};
    if (s >= (CW+1)'(DEPTH)) s = s - (CW+1)'(DEPTH);
    return s[IW-1:0];
  endfunction

  logic [AW-1:0] off;
  logic          in_win, serve, fetch, contig, full;
  logic [IW-1:0] rd_slot, app_slot, head_nx;

  assign off      = f_addr - base;
  assign in_win   = off < AW'(count);
  assign serve    = f_req & in_win & (f_branch | active);
  assign fetch    = f_req & ~serve;
  assign full     = count == CW'(DEPTH);
  assign contig   = !f_branch && (count != '0) && (f_addr == base + AW'(count));
  assign rd_slot  = slot_of(head, off[CW-1:0]);
  assign app_slot = full ? head : slot_of(head, count);
  assign head_nx  = slot_of(head, CW'(1));

  assign m_req   = fetch;
  assign m_addr  = f_addr;
  assign f_hit   = f_valid & rsp_hit;
  assign f_instr = rsp_hit ? rd_q : m_rdata;

  always_ff @(posedge clk) begin
    if (wr_pend) store[wr_slot] <= m_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base    <= '0;
      count   <= '0;
      head    <= '0;
      active  <= 1'b0;
      wr_pend <= 1'b0;
      wr_slot <= '0;
      f_valid <= 1'b0;
      rsp_hit <= 1'b0;
      rd_q    <= '0;
    end else begin
      f_valid <= f_req;
      rsp_hit <= serve;
      wr_pend <= fetch;
      if (serve) begin
        active <= 1'b1;
        rd_q   <= (wr_pend && wr_slot == rd_slot) ? m_rdata : store[rd_slot];
      end else if (fetch) begin
        active  <= 1'b0;
        wr_slot <= app_slot;
        if (contig) begin
          if (full) begin
            head <= head_nx;
            base <= base + AW'(1);
          end else begin
            count <= count + CW'(1);
          end
        end else begin
          base  <= f_addr;
          count <= CW'(1);
          head  <= '0;
          wr_slot <= '0;
        end
      end
    end
  end

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    f_req |=> f_valid);
  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !f_req |=> !f_valid);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_branch_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && f_branch && !m_req) |=> f_hit);
  assert_branch_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && f_branch && m_req) |=> (count == CW'(1) && base == $past(f_addr)));
  assert_full_slide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && full && contig) |=> (base == $past(base) + AW'(1) && full));
endmodule

// File: tb/loop_buffer_tb.sv
`timescale 1ns/1ps
module loop_buffer_tb_top;
  localparam int AW = 16, DW = 32, N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic f_req = 1'b0, f_branch = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic f_valid, f_hit, m_req;
  logic [DW-1:0] f_instr, m_rdata;
  logic [AW-1:0] m_addr;

  always #4 clk = ~clk;

  loop_buffer #(.AW(AW), .DW(DW), .DEPTH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .f_req(f_req), .f_branch(f_branch), .f_addr(f_addr),
    .f_valid(f_valid), .f_instr(f_instr), .f_hit(f_hit),
    .m_req(m_req), .m_addr(m_addr), .m_rdata(m_rdata));

  function automatic logic [DW-1:0] code(input logic [AW-1:0] a);
    return {a ^ 16'h5a3c, ~a};
  endfunction

  always_ff @(posedge clk) m_rdata <= m_req ? code(m_addr) : '0;

  int checks = 0, errors = 0, mreads = 0;
  int q[$];
  bit active = 0;
  bit exp_valid = 0, exp_hit = 0;
  logic [DW-1:0] exp_instr = '0;
  string exp_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit b, input int a, input string tag);
    bit inw, srv;
    @(negedge clk);
    chk(f_valid == exp_valid, exp_tag, "f_valid", f_valid, exp_valid);
    if (exp_valid) begin
      chk(f_hit == exp_hit, exp_tag, "f_hit", f_hit, exp_hit);
      chk(f_instr == exp_instr, exp_tag, "f_instr", f_instr, exp_instr);
    end
    f_req = r; f_branch = b; f_addr = AW'(a);
    #1;
    inw = r && q.size() > 0 && a >= q[0] && a < q[0] + q.size();
    srv = inw && (b || active);
    chk(m_req == (r && !srv), tag, "m_req", m_req, r && !srv);
    if (r && !srv) begin
      chk(m_addr == AW'(a), tag, "m_addr", m_addr, a);
      mreads++;
      if (!b && q.size() > 0 && a == q[0] + q.size()) begin
        q.push_back(a);
        if (q.size() > N) void'(q.pop_front());
      end else begin
        q = {a};
      end
      active = 0;
    end else if (srv) active = 1;
    exp_valid = r; exp_hit = srv; exp_instr = code(AW'(a)); exp_tag = tag;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(f_valid == 0, "R1", "f_valid in reset", f_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(f_valid == 0 && m_req == 0, "R1", "idle after reset", {f_valid, m_req}, 0);
    step(1, 1, 100, "R1");
    for (int a = 101; a <= 104; a++) step(1, 0, a, "R3");
    r0 = mreads;
    for (int it = 0; it < 3; it++) begin
      step(1, 1, 100, "R4");
      for (int a = 101; a <= 104; a++) step(1, 0, a, "R6");
    end
    step(0, 0, 0, "R2");
    chk(mreads == r0, "R9", "loop memory reads", mreads - r0, 0);
    for (int a = 105; a <= 112; a++) step(1, 0, a, "R6");
    step(1, 1, 100, "R8");
    for (int a = 101; a <= 109; a++) step(1, 0, a, "R8");
    step(1, 1, 101, "R8");
    step(1, 1, 102, "R8");
    step(1, 0, 103, "R6");
    step(0, 0, 0, "R2");
    step(1, 0, 300, "R10");
    step(1, 0, 301, "R10");
    step(1, 0, 302, "R10");
    step(1, 0, 301, "R7");
    step(1, 1, 301, "R4");
    step(1, 0, 302, "R6");
    step(1, 1, 302, "R2");
    step(1, 1, 303, "R5");
    step(1, 0, 304, "R3");
    step(1, 1, 303, "R4");
    step(0, 0, 0, "R2");
    step(0, 0, 0, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule